// File: doc/BRIEF.md
# Context-Tagged Parity-Checked Cache Line Lookup

This block holds the tag and data storage of a small direct-mapped cache and performs the hit check for one lookup per cycle. Each line stores an address tag, an 8-bit address-space context and one data word. A valid bit sits beside each line. The tag word (context and tag together) and the data word each carry one even-parity bit per byte. The block generates these bits when a line is filled and checks them whenever a valid line is read.

When address translation is enabled, a lookup hits only if three things hold: the line is valid, the stored tag matches, and the stored context equals the requester's context. When translation is disabled, the addresses are treated as physical and the context is ignored. A line filled in this mode stores context zero.

A parity mismatch on the line being read turns the lookup into a miss, so the requester fetches the word from memory again. It also emits a one-cycle flush request, invalidates every line, and advances a saturating error counter. Software is never involved. A two-bit corruption input inverts a stored parity bit at fill time, so that the error path can be exercised.

Top module: `ctx_tag_lookup`

## Requirements
- R1: A lookup presented with `lkp_valid_i` high at a rising edge produces exactly one result, with `res_valid_o` high in the following cycle. `res_valid_o` is low in any cycle that follows an edge without a lookup, and `hit_o` is never high without `res_valid_o`.
- R2: With `xlate_en_i` high, a lookup hits only when three conditions hold: the indexed line is valid, its stored tag equals `lkp_tag_i`, and its stored context equals `lkp_ctx_i`. A mismatch in either field gives a miss.
- R3: With `xlate_en_i` low, the stored context is not compared, and a valid line with a matching tag hits whatever the value of `lkp_ctx_i`.
- R4: A fill performed while `xlate_en_i` is low stores context zero, whatever the value of `fill_ctx_i`.
- R5: On fill, one even-parity bit is produced for each byte of the tag word {context, tag} (byte k is bits 8k+7..8k, with the top byte zero-padded) and for each byte of the data word. `fill_corrupt_i[0]` inverts the tag parity bit of byte 0, and `fill_corrupt_i[1]` inverts the data parity bit of byte 0.
- R6: A parity mismatch in the tag or data of a valid indexed line forces `hit_o` low, even when the tag and context match.
- R7: Each detected parity error raises `flush_o` for exactly the result cycle of that lookup. `flush_o` is low at all other times.
- R8: A parity error invalidates every line at the same edge that registers the result, including a line being filled in that same cycle. Later lookups miss until lines are filled again.
- R9: `err_cnt_o` rises by one for each detected parity error, holds at all ones once it gets there, and is cleared only by reset.
- R10: After reset, every line is invalid and all outputs are zero.
- R11: `data_o` carries the stored data word in a hit cycle and is zero in every other cycle.
- R12: A lookup to an invalid line never reports a parity error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| xlate_en_i | input | 1 | Address translation enabled; when high, contexts are stored and compared |
| fill_valid_i | input | 1 | Write one line this cycle |
| fill_idx_i | input | IDX_W | Line index to fill |
| fill_tag_i | input | TAG_W | Address tag to store |
| fill_ctx_i | input | 8 | Context to store (replaced by zero when translation is off) |
| fill_data_i | input | DATA_W | Data word to store |
| fill_corrupt_i | input | 2 | Test hook: bit 0 inverts tag parity byte 0, bit 1 inverts data parity byte 0 |
| lkp_valid_i | input | 1 | Lookup request this cycle |
| lkp_idx_i | input | IDX_W | Line index to look up |
| lkp_tag_i | input | TAG_W | Requested address tag |
| lkp_ctx_i | input | 8 | Requesting context |
| res_valid_o | output | 1 | Result of the previous cycle's lookup is present |
| hit_o | output | 1 | Lookup hit |
| data_o | output | DATA_W | Stored data on a hit, zero otherwise |
| flush_o | output | 1 | One-cycle whole-cache flush request after a parity error |
| err_cnt_o | output | CNT_W | Saturating count of detected parity errors |

## Verification
The assertions check every cycle that a lookup is followed by a result, that hit and flush appear only alongside a result, and that a flush never coincides with a hit. They also check that the flush lasts one cycle, that the data output is zero off a hit, and that the error counter neither decreases nor changes without a flush. The scenarios cover the rest: context matching against a reference model of the line contents, context-zero fills in physical mode, forced misses from tag and from data parity, whole-array invalidation (including a fill in the flush cycle), and counter saturation.

// File: rtl/ctxc_pkg.sv
package ctxc_pkg;
    // Width of the address-space context identifier held in each tag.
    localparam int CTX_W = 8;

    // Bits per parity-protected byte.
    localparam int BYTE_W = 8;

    // Index of the tag-parity and data-parity bits in the corruption hook.
    localparam int CORR_TAG = 0;
    localparam int CORR_DAT = 1;
endpackage

// File: rtl/ctxc_par_gen.sv
module ctxc_par_gen
    import ctxc_pkg::*;
#(
    parameter  int W  = 32,
    localparam int NB = (W + BYTE_W - 1) / BYTE_W
) (
    input  logic [W-1:0]  data_i,
    output logic [NB-1:0] par_o
);
    localparam int PW = NB * BYTE_W;

    logic [PW-1:0] padded;
    assign padded = PW'(data_i);

    // Even parity: the byte and its parity bit together hold an even count of ones.
    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign par_o[b] = ^padded[b*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/ctxc_par_chk.sv
module ctxc_par_chk
    import ctxc_pkg::*;
#(
    parameter  int W  = 32,
    localparam int NB = (W + BYTE_W - 1) / BYTE_W
) (
    input  logic [W-1:0]  data_i,
    input  logic [NB-1:0] par_i,
    output logic          err_o
);
    logic [NB-1:0] par_calc;

    ctxc_par_gen #(.W(W)) u_gen (
        .data_i (data_i),
        .par_o  (par_calc)
    );

    assign err_o = |(par_calc ^ par_i);
endmodule

// File: rtl/ctxc_tag_match.sv
module ctxc_tag_match
    import ctxc_pkg::*;
#(
    parameter int TAG_W = 20
) (
    input  logic             xlate_en_i,
    input  logic             line_vld_i,
    input  logic [TAG_W-1:0] line_tag_i,
    input  logic [CTX_W-1:0] line_ctx_i,
    input  logic [TAG_W-1:0] req_tag_i,
    input  logic [CTX_W-1:0] req_ctx_i,
    output logic             match_o
);
    logic tag_eq;
    logic ctx_ok;

    always_comb begin
        tag_eq  = (line_tag_i == req_tag_i);
        // In physical mode the context field plays no part in the hit.
        ctx_ok  = !xlate_en_i || (line_ctx_i == req_ctx_i);
        match_o = line_vld_i && tag_eq && ctx_ok;
    end
endmodule

// File: rtl/ctx_tag_lookup.sv
module ctx_tag_lookup
    import ctxc_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              xlate_en_i,
    input  logic              fill_valid_i,
    input  logic [IDX_W-1:0]  fill_idx_i,
    input  logic [TAG_W-1:0]  fill_tag_i,
    input  logic [CTX_W-1:0]  fill_ctx_i,
    input  logic [DATA_W-1:0] fill_data_i,
    input  logic [1:0]        fill_corrupt_i,
    input  logic              lkp_valid_i,
    input  logic [IDX_W-1:0]  lkp_idx_i,
    input  logic [TAG_W-1:0]  lkp_tag_i,
    input  logic [CTX_W-1:0]  lkp_ctx_i,
    output logic              res_valid_o,
    output logic              hit_o,
    output logic [DATA_W-1:0] data_o,
    output logic              flush_o,
    output logic [CNT_W-1:0]  err_cnt_o
);
    localparam int LINES = 1 << IDX_W;
    localparam int TW    = CTX_W + TAG_W;
    localparam int TPB   = (TW + BYTE_W - 1) / BYTE_W;
    localparam int DPB   = (DATA_W + BYTE_W - 1) / BYTE_W;

    typedef struct packed {
        logic [LINES-1:0]             vld;
        logic [LINES-1:0][TW-1:0]     tagw;
        logic [LINES-1:0][TPB-1:0]    tpar;
        logic [LINES-1:0][DATA_W-1:0] data;
        logic [LINES-1:0][DPB-1:0]    dpar;
        logic                         res_valid;
        logic                         hit;
        logic [DATA_W-1:0]            rdata;
        logic                         flush;
        logic [CNT_W-1:0]             cnt;
    } state_t;

    state_t s_d, s_q;

    // ---------------- fill path ----------------
    logic [CTX_W-1:0]  fill_ctx_eff;
    logic [TW-1:0]     fill_tagw;
    logic [TPB-1:0]    fill_tpar_gen, fill_tpar;
    logic [DPB-1:0]    fill_dpar_gen, fill_dpar;

    assign fill_ctx_eff = xlate_en_i ? fill_ctx_i : '0;
    assign fill_tagw    = {fill_ctx_eff, fill_tag_i};

    ctxc_par_gen #(.W(TW)) u_fill_tpar (
        .data_i (fill_tagw),
        .par_o  (fill_tpar_gen)
    );

    ctxc_par_gen #(.W(DATA_W)) u_fill_dpar (
        .data_i (fill_data_i),
        .par_o  (fill_dpar_gen)
    );

    assign fill_tpar = fill_tpar_gen ^ TPB'(fill_corrupt_i[CORR_TAG]);
    assign fill_dpar = fill_dpar_gen ^ DPB'(fill_corrupt_i[CORR_DAT]);

    // ---------------- read path ----------------
    logic              rd_vld;
    logic [TW-1:0]     rd_tagw;
    logic [TPB-1:0]    rd_tpar;
    logic [DATA_W-1:0] rd_data;
    logic [DPB-1:0]    rd_dpar;
    logic              tag_perr, dat_perr, perr, match;

    assign rd_vld  = s_q.vld[lkp_idx_i];
    assign rd_tagw = s_q.tagw[lkp_idx_i];
    assign rd_tpar = s_q.tpar[lkp_idx_i];
    assign rd_data = s_q.data[lkp_idx_i];
    assign rd_dpar = s_q.dpar[lkp_idx_i];

    ctxc_par_chk #(.W(TW)) u_chk_tag (
        .data_i (rd_tagw),
        .par_i  (rd_tpar),
        .err_o  (tag_perr)
    );

    ctxc_par_chk #(.W(DATA_W)) u_chk_dat (
        .data_i (rd_data),
        .par_i  (rd_dpar),
        .err_o  (dat_perr)
    );

    // Only a valid line's parity is meaningful.
    assign perr = lkp_valid_i && rd_vld && (tag_perr || dat_perr);

    ctxc_tag_match #(.TAG_W(TAG_W)) u_match (
        .xlate_en_i (xlate_en_i),
        .line_vld_i (rd_vld),
        .line_tag_i (rd_tagw[TAG_W-1:0]),
        .line_ctx_i (rd_tagw[TW-1:TAG_W]),
        .req_tag_i  (lkp_tag_i),
        .req_ctx_i  (lkp_ctx_i),
        .match_o    (match)
    );

    // ---------------- next state ----------------
    always_comb begin
        s_d           = s_q;
        s_d.res_valid = lkp_valid_i;
        s_d.hit       = lkp_valid_i && match && !perr;
        s_d.rdata     = s_d.hit ? rd_data : '0;
        s_d.flush     = perr;

        if (fill_valid_i) begin
            s_d.vld[fill_idx_i]  = 1'b1;
            s_d.tagw[fill_idx_i] = fill_tagw;
            s_d.tpar[fill_idx_i] = fill_tpar;
            s_d.data[fill_idx_i] = fill_data_i;
            s_d.dpar[fill_idx_i] = fill_dpar;
        end

        // The flush overrides any fill landing in the same cycle.
        if (perr) begin
            s_d.vld = '0;
            if (s_q.cnt != '1) begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign res_valid_o = s_q.res_valid;
    assign hit_o       = s_q.hit;
    assign data_o      = s_q.rdata;
    assign flush_o     = s_q.flush;
    assign err_cnt_o   = s_q.cnt;
endmodule

// File: rtl/ctx_tag_lookup_chk.sv
module ctx_tag_lookup_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              lkp_valid_i,
    input logic              res_valid_o,
    input logic              hit_o,
    input logic [DATA_W-1:0] data_o,
    input logic              flush_o,
    input logic [CNT_W-1:0]  err_cnt_o
);
    assert_result_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lkp_valid_i |=> res_valid_o);

    assert_no_spurious_result_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lkp_valid_i |=> !res_valid_o);

    assert_hit_needs_result_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> res_valid_o);

    assert_flush_is_miss_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |-> (res_valid_o && !hit_o));

    assert_flush_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |=> !flush_o);

    assert_cnt_monotonic_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (err_cnt_o >= $past(err_cnt_o)));

    assert_cnt_moves_on_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_cnt_o != $past(err_cnt_o)) |-> flush_o);

    assert_data_zero_on_miss_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit_o |-> (data_o == '0));
endmodule

bind ctx_tag_lookup ctx_tag_lookup_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_lookup_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lkp_valid_i (lkp_valid_i),
    .res_valid_o (res_valid_o),
    .hit_o       (hit_o),
    .data_o      (data_o),
    .flush_o     (flush_o),
    .err_cnt_o   (err_cnt_o)
);

// File: tb/ctx_tag_lookup_test.sv
`timescale 1ns/1ps
module ctx_tag_lookup_test;
    localparam int IDX_W  = 4;
    localparam int TAG_W  = 20;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;
    localparam int LINES  = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              xlate_en = 1'b0;
    logic              fill_valid = 1'b0;
    logic [IDX_W-1:0]  fill_idx = '0;
    logic [TAG_W-1:0]  fill_tag = '0;
    logic [7:0]        fill_ctx = '0;
    logic [DATA_W-1:0] fill_data = '0;
    logic [1:0]        fill_corrupt = '0;
    logic              lkp_valid = 1'b0;
    logic [IDX_W-1:0]  lkp_idx = '0;
    logic [TAG_W-1:0]  lkp_tag = '0;
    logic [7:0]        lkp_ctx = '0;
    logic              res_valid, hit, flush;
    logic [DATA_W-1:0] data;
    logic [CNT_W-1:0]  err_cnt;

    always #2 clk = ~clk;  // 250 MHz

    ctx_tag_lookup #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uut (
        .clk_i(clk), .rst_ni(rst_n), .xlate_en_i(xlate_en),
        .fill_valid_i(fill_valid), .fill_idx_i(fill_idx), .fill_tag_i(fill_tag),
        .fill_ctx_i(fill_ctx), .fill_data_i(fill_data), .fill_corrupt_i(fill_corrupt),
        .lkp_valid_i(lkp_valid), .lkp_idx_i(lkp_idx), .lkp_tag_i(lkp_tag), .lkp_ctx_i(lkp_ctx),
        .res_valid_o(res_valid), .hit_o(hit), .data_o(data), .flush_o(flush), .err_cnt_o(err_cnt)
    );

    typedef struct {
        bit                hit;
        logic [DATA_W-1:0] data;
        bit                flush;
        logic [CNT_W-1:0]  cnt;
        string             req;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model of the line contents, built from the requirements.
    bit                m_vld  [LINES];
    logic [TAG_W-1:0]  m_tag  [LINES];
    logic [7:0]        m_ctx  [LINES];
    logic [DATA_W-1:0] m_data [LINES];
    bit   [1:0]        m_bad  [LINES];
    int                m_cnt = 0;

    task automatic check_val(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One cycle of stimulus: optional fill and optional lookup.
    task automatic step(bit x, bit fv, int fi, logic [TAG_W-1:0] ft, logic [7:0] fc,
                        logic [DATA_W-1:0] fd, bit [1:0] fk,
                        bit lv, int li, logic [TAG_W-1:0] lt, logic [7:0] lc, string req);
        exp_t e;
        bit perr;
        xlate_en     = x;
        fill_valid   = fv;
        fill_idx     = IDX_W'(fi);
        fill_tag     = ft;
        fill_ctx     = fc;
        fill_data    = fd;
        fill_corrupt = fk;
        lkp_valid    = lv;
        lkp_idx      = IDX_W'(li);
        lkp_tag      = lt;
        lkp_ctx      = lc;
        perr = 1'b0;
        if (lv) begin
            perr    = m_vld[li] && (m_bad[li] != 2'b00);
            e.hit   = lv && m_vld[li] && !perr && (m_tag[li] == lt) && (!x || m_ctx[li] == lc);
            e.data  = e.hit ? m_data[li] : '0;
            e.flush = perr;
            if (perr && m_cnt < (1 << CNT_W) - 1) m_cnt++;
            e.cnt   = CNT_W'(m_cnt);
            e.req   = req;
        end
        if (fv) begin
            m_vld[fi]  = 1'b1;
            m_tag[fi]  = ft;
            m_ctx[fi]  = x ? fc : 8'h00;
            m_data[fi] = fd;
            m_bad[fi]  = fk;
        end
        if (perr) begin
            for (int k = 0; k < LINES; k++) m_vld[k] = 1'b0;
        end
        if (lv) exp_q.push_back(e);
        @(negedge clk);
        fill_valid = 1'b0;
        lkp_valid  = 1'b0;
        fill_corrupt = 2'b00;
    endtask

    task automatic fill(bit x, int i, logic [TAG_W-1:0] t, logic [7:0] c,
                        logic [DATA_W-1:0] d, bit [1:0] k);
        step(x, 1'b1, i, t, c, d, k, 1'b0, 0, '0, '0, "");
    endtask

    task automatic look(bit x, int i, logic [TAG_W-1:0] t, logic [7:0] c, string req);
        step(x, 1'b0, 0, '0, '0, '0, 2'b00, 1'b1, i, t, c, req);
    endtask

    // Monitor: pops one expected item per result.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                if (res_valid) begin
                    if (exp_q.size() == 0) begin
                        checks++; fails++;
                        $display("FAIL R1: unexpected result, actual res_valid=1 expected 0");
                    end else begin
                        e = exp_q.pop_front();
                        check_val(e.req, "hit",   64'(hit),     64'(e.hit));
                        check_val("R11", "data",  64'(data),    64'(e.data));
                        check_val("R7",  "flush", 64'(flush),   64'(e.flush));
                        check_val("R9",  "count", 64'(err_cnt), 64'(e.cnt));
                    end
                end else begin
                    check_val("R7", "flush without result", 64'(flush), 64'(0));
                    check_val("R1", "hit without result",   64'(hit),   64'(0));
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(4 * 100000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < LINES; k++) begin
            m_vld[k] = 1'b0; m_tag[k] = '0; m_ctx[k] = '0; m_data[k] = '0; m_bad[k] = 2'b00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state at the ports.
        check_val("R10", "res_valid", 64'(res_valid), 64'(0));
        check_val("R10", "hit",       64'(hit),       64'(0));
        check_val("R10", "flush",     64'(flush),     64'(0));
        check_val("R10", "count",     64'(err_cnt),   64'(0));
        check_val("R10", "data",      64'(data),      64'(0));
        // R10 / R12: every line invalid, no parity error from invalid lines.
        for (int k = 0; k < LINES; k++) look(1'b1, k, '0, 8'h00, "R10");

        // R2: virtual tag plus context.
        fill(1'b1, 3, 20'hABCDE, 8'h05, 32'hDEADBEEF, 2'b00);
        look(1'b1, 3, 20'hABCDE, 8'h05, "R2");
        look(1'b1, 3, 20'hABCDE, 8'h06, "R2");
        look(1'b1, 3, 20'hABCDF, 8'h05, "R2");
        look(1'b1, 7, 20'hABCDE, 8'h05, "R12");
        // R3: context ignored in physical mode.
        look(1'b0, 3, 20'hABCDE, 8'h99, "R3");
        look(1'b0, 3, 20'h12345, 8'h05, "R3");
        // R4: physical fill stores context zero.
        fill(1'b0, 4, 20'h00F0F, 8'h77, 32'h01234567, 2'b00);
        look(1'b1, 4, 20'h00F0F, 8'h00, "R4");
        look(1'b1, 4, 20'h00F0F, 8'h77, "R4");
        look(1'b0, 4, 20'h00F0F, 8'h77, "R4");

        // R5 / R6 / R7 / R8: tag parity error.
        fill(1'b1, 5, 20'h55555, 8'h11, 32'hCAFEF00D, 2'b01);
        look(1'b1, 5, 20'h55555, 8'h11, "R6");
        look(1'b1, 3, 20'hABCDE, 8'h05, "R8");
        look(1'b1, 4, 20'h00F0F, 8'h00, "R8");
        // R5: data parity error.
        fill(1'b1, 6, 20'h0AAAA, 8'h22, 32'h80000001, 2'b10);
        fill(1'b1, 3, 20'hABCDE, 8'h05, 32'h11112222, 2'b00);
        look(1'b1, 3, 20'hABCDE, 8'h05, "R5");
        look(1'b1, 6, 20'h0AAAA, 8'h22, "R5");
        look(1'b1, 3, 20'hABCDE, 8'h05, "R8");
        // R8: a fill in the flush cycle is dropped as well.
        fill(1'b1, 9, 20'h99999, 8'h09, 32'h99990000, 2'b11);
        step(1'b1, 1'b1, 10, 20'h10101, 8'h0A, 32'hA0A0A0A0, 2'b00,
             1'b1, 9, 20'h99999, 8'h09, "R8");
        look(1'b1, 10, 20'h10101, 8'h0A, "R8");
        // Refill restores hits; a faulty line elsewhere stays silent.
        fill(1'b1, 10, 20'h10101, 8'h0A, 32'h5A5A5A5A, 2'b00);
        fill(1'b1, 11, 20'h0BBBB, 8'h0B, 32'h0, 2'b01);
        look(1'b1, 10, 20'h10101, 8'h0A, "R11");
        look(1'b1, 12, 20'h10101, 8'h0A, "R12");

        // R9: saturation of the error counter.
        for (int n = 0; n < (1 << CNT_W) + 4; n++) begin
            fill(1'b1, 1, 20'h00001, 8'h01, 32'h1, 2'b10);
            look(1'b1, 1, 20'h00001, 8'h01, "R9");
        end
        fill(1'b1, 2, 20'h00002, 8'h02, 32'h2, 2'b00);
        look(1'b1, 2, 20'h00002, 8'h02, "R9");

        repeat (3) @(negedge clk);
        done = 1'b1;
        check_val("R1", "pending results", 64'(exp_q.size()), 64'(0));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule